// File: doc/BRIEF.md
# Reset Pulse Width Qualifier

This block watches an active-low reset pin from outside the chip and decides, using a free-running system clock, whether each low pulse is a real reset request or a spike to ignore. The pin first goes through a synchronizer. The block then counts how long the synchronized pin stays low. If the low time reaches `ACCEPT_CYC` clock cycles, the block issues a one-cycle accept strobe and raises a level that marks a reset in progress.

Pulses shorter than `REJECT_CYC` cycles never produce a strobe. For low times between `REJECT_CYC` and `ACCEPT_CYC` the outcome is left open to the implementation. This one accepts only at `ACCEPT_CYC`.

A short high blip inside a low pulse does not restart the measurement, and it does not end a reset that is already in progress. High time shorter than `GLITCH_CYC` cycles is absorbed: the low time on both sides of it is added together. High time of `GLITCH_CYC` cycles or more ends the pulse.

The controller is a five-state machine:

- `ST_IDLE` means the pin is high and nothing is being measured.
- `ST_MEASURE` means the pin is low and low cycles are being counted.
- `ST_MEAS_GAP` means a high blip has arrived before acceptance.
- `ST_HELD` means the pulse was accepted and the pin is still low.
- `ST_HELD_GAP` means a high blip has arrived after acceptance.

Its transitions are:

- *start*: `ST_IDLE` to `ST_MEASURE`, on the first low sample.
- *blip*: `ST_MEASURE` to `ST_MEAS_GAP`, or `ST_HELD` to `ST_HELD_GAP`, on a high sample.
- *resume*: `ST_MEAS_GAP` to `ST_MEASURE`, or `ST_HELD_GAP` to `ST_HELD`, on a low sample before the blip limit.
- *qualify*: `ST_MEASURE` or `ST_MEAS_GAP` to `ST_HELD`, on the `ACCEPT_CYC`-th low sample. This transition fires the strobe.
- *release*: either gap state to `ST_IDLE`, on the `GLITCH_CYC`-th consecutive high sample.

Top module: `rst_pulse_qual`

## Requirements
- R1: While `arst_n` is low, `accept_o` and `resetting_o` are 0, including when the block is reset during an accepted pulse.
- R2: A low pulse whose total low time is below `REJECT_CYC` cycles produces no strobe, and `resetting_o` stays 0.
- R3: A low pulse of `ACCEPT_CYC` cycles or longer produces exactly one `accept_o` strobe.
- R4: The strobe is high in the clock cycle that begins `ACCEPT_CYC`+2 rising edges after the first rising edge that samples `pin_n` low. The two extra edges are the two synchronizer stages.
- R5: `accept_o` is high for exactly one cycle, and at most once per pulse, however long the pin stays low.
- R6: A high blip shorter than `GLITCH_CYC` cycles inside a low pulse is absorbed. This holds both before and after acceptance. The low time on both sides is summed toward `ACCEPT_CYC`, and a second strobe is never produced.
- R7: High time of `GLITCH_CYC` cycles or more ends the pulse. The low stretches on either side are then judged as separate pulses.
- R8: `resetting_o` rises together with the strobe. It stays 1 through absorbed blips. It falls `GLITCH_CYC`+2 cycles after `pin_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| arst_n | input | 1 | Asynchronous active-low reset of this block |
| pin_n | input | 1 | External active-low reset pin, asynchronous to clk |
| accept_o | output | 1 | One-cycle strobe when a low pulse qualifies |
| resetting_o | output | 1 | High from acceptance until the pin is released |

## Verification
The bench builds the block with `ACCEPT_CYC`=20, `REJECT_CYC`=10 and `GLITCH_CYC`=4. These are scaled-down stand-ins for real microsecond counts at 50 MHz. With these values every boundary can be reached in a few dozen cycles:

- a pulse of exactly 20 cycles, and pulses well below 10 cycles;
- blips of 3 cycles, which are absorbed, and of 4 cycles, which end the pulse;
- a split pulse whose halves sum to exactly 20.

Totals that fall between 10 and 19 cycles are kept out of the stimulus, because the outcome there is left open.

// File: rtl/rpq_pkg.sv
package rpq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_MEAS_GAP,
        ST_HELD,
        ST_HELD_GAP
    } rpq_state_e;
endpackage

// File: rtl/rpq_sync.sv
module rpq_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rpq_counter.sv
module rpq_counter #(
    parameter int LIMIT = 20,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          start,
    input  logic          step,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(1);
        end else if (step && (cnt_q != LIM_V)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == LAST_V);

    // R6 R7: the counter never runs past its limit
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= LIM_V);

    // R7: a start always lands on one
    p_start_loads_one_r7: assert property (@(posedge clk) disable iff (!arst_n)
        start |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/rst_pulse_qual.sv
module rst_pulse_qual #(
    parameter int ACCEPT_CYC  = 20,
    parameter int REJECT_CYC  = 10,
    parameter int GLITCH_CYC  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int LCW        = $clog2(ACCEPT_CYC + 1),
    localparam int GCW        = $clog2(GLITCH_CYC + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_n,
    output logic accept_o,
    output logic resetting_o
);
    import rpq_pkg::*;

    logic           pin_s;
    logic           low_start, low_step, low_last;
    logic           gap_start, gap_step, gap_last;
    logic [LCW-1:0] low_cnt;
    logic [GCW-1:0] gap_cnt;
    logic           fire;
    rpq_state_e     state_q, state_d;
    logic           accept_q, held_q;

    rpq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_in   (pin_n),
        .q_out  (pin_s)
    );

    rpq_counter #(.LIMIT(ACCEPT_CYC)) u_low_cnt (
        .clk    (clk),
        .arst_n (arst_n),
        .start  (low_start),
        .step   (low_step),
        .cnt_o  (low_cnt),
        .last_o (low_last)
    );

    rpq_counter #(.LIMIT(GLITCH_CYC)) u_gap_cnt (
        .clk    (clk),
        .arst_n (arst_n),
        .start  (gap_start),
        .step   (gap_step),
        .cnt_o  (gap_cnt),
        .last_o (gap_last)
    );

    // next-state and counter control
    always_comb begin
        state_d   = state_q;
        low_start = 1'b0;
        low_step  = 1'b0;
        gap_start = 1'b0;
        gap_step  = 1'b0;
        fire      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!pin_s) begin
                    state_d   = ST_MEASURE;
                    low_start = 1'b1;
                end
            end
            ST_MEASURE: begin
                if (pin_s) begin
                    state_d   = ST_MEAS_GAP;
                    gap_start = 1'b1;
                end else if (low_last) begin
                    state_d = ST_HELD;
                    fire    = 1'b1;
                end else begin
                    low_step = 1'b1;
                end
            end
            ST_MEAS_GAP: begin
                if (pin_s) begin
                    if (gap_last) state_d = ST_IDLE;
                    else          gap_step = 1'b1;
                end else if (low_last) begin
                    state_d = ST_HELD;
                    fire    = 1'b1;
                end else begin
                    state_d  = ST_MEASURE;
                    low_step = 1'b1;
                end
            end
            ST_HELD: begin
                if (pin_s) begin
                    state_d   = ST_HELD_GAP;
                    gap_start = 1'b1;
                end
            end
            ST_HELD_GAP: begin
                if (pin_s) begin
                    if (gap_last) state_d = ST_IDLE;
                    else          gap_step = 1'b1;
                end else begin
                    state_d = ST_HELD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            accept_q <= 1'b0;
            held_q   <= 1'b0;
        end else begin
            accept_q <= fire;
            held_q   <= (state_d == ST_HELD) || (state_d == ST_HELD_GAP);
        end
    end

    assign accept_o    = accept_q;
    assign resetting_o = held_q;

    p_strobe_one_cycle_r5: assert property (@(posedge clk) disable iff (!arst_n)
        accept_o |=> !accept_o);

    p_no_second_strobe_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (resetting_o && $past(resetting_o)) |-> !accept_o);

    p_level_with_strobe_r8: assert property (@(posedge clk) disable iff (!arst_n)
        accept_o |-> resetting_o);

    p_level_rise_r8: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(resetting_o) |-> accept_o);

    p_strobe_in_held_r3: assert property (@(posedge clk) disable iff (!arst_n)
        accept_o |-> (state_q == ST_HELD));

    p_accept_floor_r2: assert property (@(posedge clk) disable iff (!arst_n)
        accept_o |-> (int'(low_cnt) >= REJECT_CYC - 1));

    p_gap_bounded_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_MEAS_GAP || state_q == ST_HELD_GAP) |-> (int'(gap_cnt) < GLITCH_CYC));
endmodule

// File: tb/rst_pulse_qual_tb.sv
`timescale 1ns/1ps
module rst_pulse_qual_tb;
    localparam int A = 20;
    localparam int R = 10;
    localparam int G = 4;
    localparam int NV = 10;

    // columns: low1, blip, low2, expected strobes, requirement number
    localparam int VEC [NV][5] = '{
        '{ 3, 0,  0, 0, 2},  // R2 tiny spike
        '{ 9, 0,  0, 0, 2},  // R2 just under floor
        '{20, 0,  0, 1, 3},  // R3 exactly accept length
        '{60, 0,  0, 1, 5},  // R5 long pulse, single strobe
        '{12, 3, 12, 1, 6},  // R6 absorbed blip, summed
        '{ 4, 1,  4, 0, 6},  // R6 absorbed, sum still short
        '{19, 1,  1, 1, 6},  // R6 sum hits accept exactly
        '{22, 2, 30, 1, 6},  // R6 blip after accept
        '{ 8, 4,  8, 0, 7},  // R7 blip splits two short pulses
        '{25, 4, 25, 2, 7}   // R7 blip splits two long pulses
    };

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic pin_n = 1'b1;
    logic accept_o, resetting_o;
    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rst_pulse_qual #(.ACCEPT_CYC(A), .REJECT_CYC(R), .GLITCH_CYC(G)) u_dut (
        .clk         (clk),
        .arst_n      (arst_n),
        .pin_n       (pin_n),
        .accept_o    (accept_o),
        .resetting_o (resetting_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk);
        if (accept_o) strobes++;
        pin_n = v;
    endtask

    initial begin
        int first;
        repeat (3) @(negedge clk);
        chk("R1 reset accept", accept_o, 0);
        chk("R1 reset level", resetting_o, 0);
        arst_n = 1'b1;
        repeat (5) tick(1'b1);
        chk("R1 idle accept", accept_o, 0);

        for (int i = 0; i < NV; i++) begin
            strobes = 0;
            for (int k = 0; k < VEC[i][0]; k++) tick(1'b0);
            for (int k = 0; k < VEC[i][1]; k++) tick(1'b1);
            for (int k = 0; k < VEC[i][2]; k++) tick(1'b0);
            for (int k = 0; k < 14; k++) tick(1'b1);
            chk($sformatf("R%0d vec%0d strobes", VEC[i][4], i), strobes, VEC[i][3]);
            chk($sformatf("R8 vec%0d level released", i), resetting_o, 0);
        end

        // R4 latency and R8 level behaviour
        first = 0;
        @(negedge clk);
        pin_n = 1'b0;
        for (int j = 1; j <= A + 3; j++) begin
            @(negedge clk);
            if (accept_o && first == 0) first = j;
        end
        chk("R4 strobe latency", first, A + 2);
        chk("R8 level held", resetting_o, 1);
        chk("R5 strobe dropped", accept_o, 0);
        pin_n = 1'b1;
        for (int j = 1; j <= G - 1; j++) begin
            @(negedge clk);
            chk("R8 level through blip", resetting_o, 1);
        end
        pin_n = 1'b0;
        for (int j = 1; j <= G + 3; j++) begin
            @(negedge clk);
            chk("R6 no restrobe after blip", accept_o, 0);
        end
        chk("R8 level after blip", resetting_o, 1);
        pin_n = 1'b1;
        for (int j = 1; j <= G + 2; j++) begin
            @(negedge clk);
            if (j == G + 1) chk("R8 level before release", resetting_o, 1);
            if (j == G + 2) chk("R8 level released", resetting_o, 0);
        end

        // R1 reset in the middle of an accepted pulse
        repeat (5) tick(1'b1);
        for (int k = 0; k < A + 6; k++) tick(1'b0);
        chk("R1 pre-reset level", resetting_o, 1);
        arst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-pulse reset level", resetting_o, 0);
        chk("R1 mid-pulse reset accept", accept_o, 0);
        pin_n = 1'b1;
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 after reset level", resetting_o, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule